// File: doc/BRIEF.md
# Line Calibration Sequencer

This block orders the two calibrations that a telephone line interface needs once the line changes state. The first is a resistor calibration and the second an offset calibration of the line-side converter. An off-hook event or a loss of line power starts the sequence automatically. The resistor step runs first unless its disable bit is set. The converter step then waits until the dc termination reports that it has settled.

Software can block the automatic starts. Once they are blocked, it can run a converter calibration on its own by writing 1 and then 0 to a manual-calibration bit. The analog calibration circuits are not modelled. Each step is timed with a millisecond tick: a one-cycle start strobe goes to the analog side, a busy flag stays high while the step runs, and a done flag marks the end of the last step.

Top module: `line_cal_seq`

## Requirements
- R1: After reset both busy flags, both start strobes and the done flag are 0.
- R2: A one-cycle pulse on off_hook_evt or pwr_loss_evt while auto_cal_dis is 0 and rcal_dis is 0 raises rcal_busy and gives a one-cycle rcal_start pulse on the next clock edge.
- R3: rcal_busy stays high until RCAL_MS ticks have been seen after the start. It falls within two clock cycles after the last of those ticks.
- R4: With rcal_dis at 1, an automatic trigger gives no rcal_start pulse and no rcal_busy. The sequence goes straight to the converter step.
- R5: The converter step of an automatic sequence starts only when dc_stable is 1 after the resistor step has ended or been skipped. adc_start then pulses for one cycle and adc_busy rises.
- R6: adc_busy stays high until ADC_MS ticks have been seen after adc_start. It falls within two clock cycles after the last of those ticks.
- R7: While auto_cal_dis is 1, off-hook and power-loss pulses start nothing and leave cal_done unchanged.
- R8: A 1-to-0 change of man_cal while auto_cal_dis is 1 starts a converter calibration at once, without the resistor step and without waiting for dc_stable. A rising edge of man_cal does nothing. A toggle made while auto_cal_dis is 0 does nothing.
- R9: A trigger that arrives while a calibration is running restarts the sequence. For an automatic trigger this begins again at the resistor step with a fresh full duration.
- R10: cal_done goes to 1 on the clock edge where the last enabled step ends. It goes to 0 on the edge that accepts the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| off_hook_evt | input | 1 | One-cycle pulse when the line goes off-hook |
| pwr_loss_evt | input | 1 | One-cycle pulse on loss of line power |
| dc_stable | input | 1 | The dc termination has settled |
| rcal_dis | input | 1 | Skip the resistor calibration |
| auto_cal_dis | input | 1 | Block the automatic starts and allow manual starts |
| man_cal | input | 1 | Manual-calibration control bit; its falling edge starts a converter calibration |
| rcal_busy | output | 1 | Resistor calibration running |
| adc_busy | output | 1 | Converter calibration running |
| rcal_start | output | 1 | One-cycle start strobe to the resistor calibration circuit |
| adc_start | output | 1 | One-cycle start strobe to the converter calibration circuit |
| cal_done | output | 1 | Last enabled calibration step has finished |

## Verification
The bench builds the block with RCAL_MS set to 4 and ADC_MS set to 6, and it supplies ms_tick itself. With these values every step runs from its start to its end within a few dozen clock cycles. That brings within reach the edge cases: the tick just before expiry, the tick that ends a step, and a restart in the middle of a resistor step. With the defaults of 17 and 256 these cases would need thousands of cycles.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RCAL = 2'd1,
        ST_WDC  = 2'd2,
        ST_ADC  = 2'd3
    } lcs_state_e;

    typedef struct packed {
        lcs_state_e st;
        logic       rcal_go;
        logic       adc_go;
        logic       done;
    } lcs_regs_t;
endpackage

// File: rtl/lcs_fall_det.sv
module lcs_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din;
        fall   = prev_q & ~din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/lcs_timer.sv
module lcs_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                      cnt_d = load_val;
        else if (tick && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        zero = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/line_cal_seq.sv
module line_cal_seq #(
    parameter int RCAL_MS = 17,
    parameter int ADC_MS  = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic off_hook_evt,
    input  logic pwr_loss_evt,
    input  logic dc_stable,
    input  logic rcal_dis,
    input  logic auto_cal_dis,
    input  logic man_cal,
    output logic rcal_busy,
    output logic adc_busy,
    output logic rcal_start,
    output logic adc_start,
    output logic cal_done
);
    import lcs_pkg::*;

    localparam int MAX_MS = (ADC_MS > RCAL_MS) ? ADC_MS : RCAL_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);
    localparam logic [CNT_W-1:0] RCAL_LD = CNT_W'(RCAL_MS);
    localparam logic [CNT_W-1:0] ADC_LD  = CNT_W'(ADC_MS);

    lcs_regs_t        r_d, r_q;
    logic             man_fall, auto_trig, man_trig;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    lcs_fall_det i_man_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (man_cal),
        .fall (man_fall)
    );

    lcs_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .tick    (ms_tick),
        .zero    (tmr_zero)
    );

    always_comb begin
        auto_trig  = (off_hook_evt | pwr_loss_evt) & ~auto_cal_dis;
        man_trig   = man_fall & auto_cal_dis;
        r_d        = r_q;
        r_d.rcal_go = 1'b0;
        r_d.adc_go  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;

        // normal progress through the steps
        unique case (r_q.st)
            ST_RCAL: if (tmr_zero) r_d.st = ST_WDC;
            ST_WDC: if (dc_stable) begin
                r_d.st     = ST_ADC;
                r_d.adc_go = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = ADC_LD;
            end
            ST_ADC: if (tmr_zero) begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            default: ;
        endcase

        // a trigger overrides whatever step is in progress
        if (auto_trig) begin
            r_d.done   = 1'b0;
            r_d.adc_go = 1'b0;
            tmr_load   = 1'b0;
            if (rcal_dis) begin
                r_d.st = ST_WDC;
            end else begin
                r_d.st      = ST_RCAL;
                r_d.rcal_go = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = RCAL_LD;
            end
        end else if (man_trig) begin
            r_d.done   = 1'b0;
            r_d.st     = ST_ADC;
            r_d.adc_go = 1'b1;
            tmr_load   = 1'b1;
            tmr_val    = ADC_LD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, rcal_go: 1'b0, adc_go: 1'b0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign rcal_busy  = (r_q.st == ST_RCAL);
    assign adc_busy   = (r_q.st == ST_ADC);
    assign rcal_start = r_q.rcal_go;
    assign adc_start  = r_q.adc_go;
    assign cal_done   = r_q.done;
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker (
    input logic clk,
    input logic rst_n,
    input logic rcal_dis,
    input logic auto_cal_dis,
    input logic rcal_busy,
    input logic adc_busy,
    input logic rcal_start,
    input logic adc_start,
    input logic cal_done
);
    p_rcal_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rcal_start |=> !rcal_start);

    p_rcal_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rcal_start |-> rcal_busy);

    p_skip_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rcal_start |-> !$past(rcal_dis));

    p_adc_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (adc_busy && !rcal_busy));

    p_adc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    p_auto_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        auto_cal_dis |=> !rcal_start);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (!rcal_busy && !adc_busy));

    p_done_after_adc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(adc_busy));
endmodule

bind line_cal_seq lcs_checker i_lcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rcal_dis    (rcal_dis),
    .auto_cal_dis(auto_cal_dis),
    .rcal_busy   (rcal_busy),
    .adc_busy    (adc_busy),
    .rcal_start  (rcal_start),
    .adc_start   (adc_start),
    .cal_done    (cal_done)
);

// File: tb/test_line_cal_seq.sv
module test_line_cal_seq;
    localparam int RCAL_N = 4;
    localparam int ADC_N  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, off_hook_evt = 1'b0, pwr_loss_evt = 1'b0;
    logic dc_stable = 1'b0, rcal_dis = 1'b0, auto_cal_dis = 1'b0, man_cal = 1'b0;
    logic rcal_busy, adc_busy, rcal_start, adc_start, cal_done;
    int   total = 0, bad = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    line_cal_seq #(.RCAL_MS(RCAL_N), .ADC_MS(ADC_N)) i_line_cal_seq (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .off_hook_evt(off_hook_evt), .pwr_loss_evt(pwr_loss_evt),
        .dc_stable(dc_stable), .rcal_dis(rcal_dis), .auto_cal_dis(auto_cal_dis),
        .man_cal(man_cal), .rcal_busy(rcal_busy), .adc_busy(adc_busy),
        .rcal_start(rcal_start), .adc_start(adc_start), .cal_done(cal_done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic pulse_hook();
        @(negedge clk) off_hook_evt = 1'b1;
        @(negedge clk) off_hook_evt = 1'b0;
    endtask

    task automatic pulse_pwr();
        @(negedge clk) pwr_loss_evt = 1'b1;
        @(negedge clk) pwr_loss_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rcal_busy", rcal_busy, 1'b0);
        chk("R1", "adc_busy", adc_busy, 1'b0);
        chk("R1", "rcal_start", rcal_start, 1'b0);
        chk("R1", "adc_start", adc_start, 1'b0);
        chk("R1", "cal_done", cal_done, 1'b0);
    endtask

    task automatic t_auto_full();
        dc_stable = 1'b0;
        pulse_hook();
        chk("R2", "rcal_start", rcal_start, 1'b1);
        chk("R2", "rcal_busy", rcal_busy, 1'b1);
        @(negedge clk);
        chk("R2", "rcal_start one cycle", rcal_start, 1'b0);
        ticks(RCAL_N - 1);
        chk("R3", "busy before last tick", rcal_busy, 1'b1);
        ticks(1);
        @(negedge clk);
        chk("R3", "busy after last tick", rcal_busy, 0);
        ticks(2);
        chk("R5", "adc waits for dc", adc_busy, 1'b0);
        chk("R5", "no adc_start", adc_start, 1'b0);
        dc_stable = 1'b1;
        @(negedge clk);
        chk("R5", "adc_start", adc_start, 1'b1);
        chk("R5", "adc_busy", adc_busy, 1'b1);
        @(negedge clk);
        chk("R5", "adc_start one cycle", adc_start, 1'b0);
        ticks(ADC_N - 1);
        chk("R6", "adc busy before last tick", adc_busy, 1'b1);
        chk("R10", "done not yet", cal_done, 1'b0);
        ticks(1);
        @(negedge clk);
        chk("R6", "adc busy after last tick", adc_busy, 1'b0);
        chk("R10", "done set", cal_done, 1'b1);
    endtask

    task automatic t_skip_rcal();
        rcal_dis = 1'b1;
        dc_stable = 1'b1;
        pulse_pwr();
        chk("R4", "no rcal_start", rcal_start, 1'b0);
        chk("R4", "no rcal_busy", rcal_busy, 1'b0);
        chk("R10", "done cleared by trigger", cal_done, 1'b0);
        @(negedge clk);
        chk("R4", "adc_start", adc_start, 1'b1);
        chk("R4", "adc_busy", adc_busy, 1'b1);
        ticks(ADC_N);
        @(negedge clk);
        chk("R10", "done after adc", cal_done, 1'b1);
        rcal_dis = 1'b0;
    endtask

    task automatic t_auto_blocked();
        auto_cal_dis = 1'b1;
        pulse_hook();
        pulse_pwr();
        repeat (2) @(negedge clk);
        chk("R7", "rcal_busy", rcal_busy, 1'b0);
        chk("R7", "adc_busy", adc_busy, 1'b0);
        chk("R7", "done kept", cal_done, 1'b1);
    endtask

    task automatic t_manual();
        dc_stable = 1'b0;
        @(negedge clk) man_cal = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "rise does nothing", adc_busy, 1'b0);
        chk("R8", "done kept on rise", cal_done, 1'b1);
        man_cal = 1'b0;
        @(negedge clk);
        chk("R8", "adc_start", adc_start, 1'b1);
        chk("R8", "adc_busy", adc_busy, 1'b1);
        chk("R8", "no rcal", rcal_busy, 1'b0);
        chk("R10", "done cleared", cal_done, 1'b0);
        ticks(ADC_N);
        @(negedge clk);
        chk("R8", "manual ends", adc_busy, 1'b0);
        chk("R10", "done after manual", cal_done, 1'b1);
        auto_cal_dis = 1'b0;
        @(negedge clk) man_cal = 1'b1;
        @(negedge clk) man_cal = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "toggle ignored when auto on", adc_busy, 1'b0);
        chk("R8", "done kept when auto on", cal_done, 1'b1);
    endtask

    task automatic t_restart();
        pulse_hook();
        ticks(2);
        pulse_hook();
        chk("R9", "rcal_start again", rcal_start, 1'b1);
        ticks(RCAL_N - 1);
        chk("R9", "still busy after restart", rcal_busy, 1'b1);
        ticks(1);
        @(negedge clk);
        chk("R9", "ends after full time", rcal_busy, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto_full();
        t_skip_rcal();
        t_auto_blocked();
        t_manual();
        t_restart();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule